// File: doc/BRIEF.md
# Replicated Pipelined Reset Distributor

This block turns one active-low asynchronous reset input into a set of separate active-low reset outputs, one for each downstream logic region. The reset load is no longer carried by one high-fanout net. Each region gets its own copy of the final reset registers, so those registers can sit next to the logic they drive.

Entry into reset is asynchronous. Every register in the tree is cleared straight from the input reset, so all outputs go low at once, with or without a running clock. Exit from reset is synchronous. The release first passes a two-flop synchronizer. It then passes a shared trunk of pipeline registers. Last, it passes each region's own branch of pipeline registers. The final register of every branch samples on the falling clock edge. All branches have the same depth, so every region leaves reset on the same falling edge.

The release latency is 2 + TRUNK_STAGES + BRANCH_STAGES rising edges plus half a clock period. It is counted from the first rising edge after the input goes high.

Top module: `rst_fanout_tree`

## Requirements
- R1: When `arst_n_i` falls, every bit of `region_rst_n_o` becomes 0 in the same time step, without any clock edge.
- R2: While `arst_n_i` is held at 0, every bit of `region_rst_n_o` stays 0 whatever the clock does.
- R3: Let L = 2 + TRUNK_STAGES + BRANCH_STAGES (4 with the default values). After `arst_n_i` rises between clock edges, the outputs stay 0 through the first L rising edges. They become 1 on the falling edge that follows the L-th rising edge.
- R4: All bits of `region_rst_n_o` always hold the same value. No region leaves reset on a different edge from the others.
- R5: Outputs change from 0 to 1 only on a falling clock edge. Just after the L-th rising edge they are still 0.
- R6: A low pulse on `arst_n_i` shorter than one clock period drives all outputs to 0. After that pulse, the release takes the full latency of R3.
- R7: If `arst_n_i` falls again while a release is still moving through the pipeline, the outputs stay 0. The next release again takes the full latency of R3, counted from the new rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. The synchronizer and pipeline use its rising edge; each region's final register uses its falling edge |
| arst_n_i | input | 1 | External asynchronous reset, active low |
| region_rst_n_o | output | NUM_REGIONS | Per-region reset, active low; bit i drives region i |

## Verification
The two functions that can fall in the same cycle are reset assertion and an unfinished release. A new fall of the input can arrive while a 1 is still moving down the synchronizer and pipeline. The bench provokes this by releasing the input, letting two rising edges pass, and pulling the input low again between edges. It then checks that all outputs are 0 one nanosecond later. It also checks that the next release needs the full count of rising edges plus the falling-edge half cycle, so no stale 1 left in the pipeline can shorten it. Pulses shorter than a clock period, and releases in both the high and the low clock phase, are run from a vector table in the same way.

// File: rtl/rst_tree_pkg.sv
package rst_tree_pkg;

  // Depth of the release synchronizer at the root of the tree.
  localparam int unsigned SYNC_DEPTH = 2;

  // Active-low reset levels.
  localparam logic RST_ON  = 1'b0;
  localparam logic RST_OFF = 1'b1;

  // Rising edges from the first edge after release to the last rising-edge register.
  function automatic int unsigned release_edges(input int unsigned trunk,
                                                input int unsigned branch);
    return SYNC_DEPTH + trunk + branch;
  endfunction

endpackage

// File: rtl/rst_sync_2ff.sv
module rst_sync_2ff
  import rst_tree_pkg::*;
(
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_d;

  // Shift the inactive level in from the bottom.
  always_comb begin
    sync_d = {sync_q[SYNC_DEPTH-2:0], RST_OFF};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sync_q <= {SYNC_DEPTH{RST_ON}};
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[SYNC_DEPTH-1];

endmodule

// File: rtl/rst_pipe.sv
module rst_pipe
  import rst_tree_pkg::*;
#(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  generate
    if (STAGES == 0) begin : g_wire
      assign rst_n_o = rst_n_i;
    end else if (STAGES == 1) begin : g_one
      logic stage_q;
      logic stage_d;

      always_comb begin
        stage_d = rst_n_i;
      end

      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
          stage_q <= RST_ON;
        end else begin
          stage_q <= stage_d;
        end
      end

      assign rst_n_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      logic [STAGES-1:0] stage_d;

      always_comb begin
        stage_d = {stage_q[STAGES-2:0], rst_n_i};
      end

      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
          stage_q <= {STAGES{RST_ON}};
        end else begin
          stage_q <= stage_d;
        end
      end

      assign rst_n_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rst_region_branch.sv
module rst_region_branch
  import rst_tree_pkg::*;
#(
  parameter int unsigned BRANCH_STAGES = 1
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic trunk_rst_n_i,
  output logic region_rst_n_o
);

  logic branch_rst_n;
  logic final_d;
  logic final_q;

  // Per-region replica of the rising-edge pipeline.
  rst_pipe #(
    .STAGES (BRANCH_STAGES)
  ) pipe_i (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_i  (trunk_rst_n_i),
    .rst_n_o  (branch_rst_n)
  );

  always_comb begin
    final_d = branch_rst_n;
  end

  // Final register on the falling edge: half a cycle of margin to the loads.
  always_ff @(negedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      final_q <= RST_ON;
    end else begin
      final_q <= final_d;
    end
  end

  assign region_rst_n_o = final_q;

endmodule

// File: rtl/rst_fanout_tree.sv
module rst_fanout_tree
  import rst_tree_pkg::*;
#(
  parameter int unsigned NUM_REGIONS   = 4,
  parameter int unsigned TRUNK_STAGES  = 1,
  parameter int unsigned BRANCH_STAGES = 1
) (
  input  logic                   clk_i,
  input  logic                   arst_n_i,
  output logic [NUM_REGIONS-1:0] region_rst_n_o
);

  logic sync_rst_n;
  logic trunk_rst_n;

  rst_sync_2ff sync_i (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (sync_rst_n)
  );

  rst_pipe #(
    .STAGES (TRUNK_STAGES)
  ) trunk_i (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_i  (sync_rst_n),
    .rst_n_o  (trunk_rst_n)
  );

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      rst_region_branch #(
        .BRANCH_STAGES (BRANCH_STAGES)
      ) branch_i (
        .clk_i          (clk_i),
        .arst_n_i       (arst_n_i),
        .trunk_rst_n_i  (trunk_rst_n),
        .region_rst_n_o (region_rst_n_o[r])
      );
    end
  endgenerate

endmodule

// File: rtl/rst_tree_chk.sv
module rst_tree_chk #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned LAT         = 4
) (
  input logic                   clk_i,
  input logic                   arst_n_i,
  input logic [NUM_REGIONS-1:0] rst_n_o
);

  localparam int unsigned CW = $clog2(LAT + 2);

  // Rising edges since release, saturating at LAT+1.
  logic [CW-1:0] edge_cnt;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      edge_cnt <= '0;
    end else if (edge_cnt != CW'(LAT + 1)) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // R2
  held_low_chk: assert property (@(posedge clk_i) !arst_n_i |-> (rst_n_o == '0));

  // R4
  regions_match_chk: assert property (@(negedge clk_i) disable iff (!arst_n_i)
    (rst_n_o == '0) || (rst_n_o == '1));

  // R3
  early_release_chk: assert property (@(negedge clk_i) disable iff (!arst_n_i)
    (edge_cnt <= CW'(LAT)) |-> (rst_n_o == '0));

  // R5
  late_release_chk: assert property (@(negedge clk_i) disable iff (!arst_n_i)
    (edge_cnt == CW'(LAT + 1)) |-> (rst_n_o == '1));

endmodule

bind rst_fanout_tree rst_tree_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .LAT         (rst_tree_pkg::release_edges(TRUNK_STAGES, BRANCH_STAGES))
) chk_i (
  .clk_i    (clk_i),
  .arst_n_i (arst_n_i),
  .rst_n_o  (region_rst_n_o)
);

// File: tb/rst_fanout_tree_tb.sv
module rst_fanout_tree_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 4;
  localparam int TRUNK  = 1;
  localparam int BRANCH = 1;
  localparam int LAT    = 2 + TRUNK + BRANCH;
  localparam logic [NREG-1:0] ALL_LOW  = '0;
  localparam logic [NREG-1:0] ALL_HIGH = '1;

  // Each vector: {time after a rising edge at which reset falls, low time in ns}.
  // Rise times avoid the clock edges (multiples of 5 ns after a rising edge).
  localparam int NVEC = 4;
  localparam int VEC [NVEC][2] = '{
    '{2, 4},
    '{7, 25},
    '{1, 3},
    '{6, 41}
  };

  logic            clk;
  logic            arst_n;
  logic [NREG-1:0] rst_n_o;
  int              checks;
  int              errors;

  rst_fanout_tree #(
    .NUM_REGIONS   (NREG),
    .TRUNK_STAGES  (TRUNK),
    .BRANCH_STAGES (BRANCH)
  ) dut_i (
    .clk_i          (clk),
    .arst_n_i       (arst_n),
    .region_rst_n_o (rst_n_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [NREG-1:0] exp);
    checks++;
    if (rst_n_o !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, rst_n_o, exp, $time);
    end
  endtask

  // Called right after the input has risen between edges.
  task automatic expect_release(input string req);
    for (int n = 1; n <= LAT; n++) begin
      @(posedge clk);
      #1;
      if (n == LAT) chk({req, " R5 still low after last rising edge"}, ALL_LOW);
      else          chk({req, " R3 low during release"}, ALL_LOW);
    end
    @(negedge clk);
    #1;
    chk({req, " R3 R4 all high on falling edge"}, ALL_HIGH);
    @(negedge clk);
    #1;
    chk({req, " R4 stays high"}, ALL_HIGH);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    arst_n = 1'b0;
    #1;
    chk("R1 reset state before any clock", ALL_LOW);

    // R2: held low across many edges
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      #2;
      chk("R2 held low after rising edge", ALL_LOW);
      @(negedge clk);
      #2;
      chk("R2 held low after falling edge", ALL_LOW);
    end
    @(posedge clk);
    #3;
    arst_n = 1'b1;
    expect_release("initial");

    // Vector table: assertion timing and pulse width
    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk);
      #(VEC[v][0]);
      arst_n = 1'b0;
      #1;
      if (VEC[v][1] < CLK_PERIOD) chk("R6 short pulse asserts at once", ALL_LOW);
      else                        chk("R1 asserts without clock edge", ALL_LOW);
      #(VEC[v][1] - 1);
      arst_n = 1'b1;
      if (VEC[v][1] < CLK_PERIOD) expect_release("R6 short pulse");
      else                        expect_release("vector");
    end

    // R7: reassert while the release is in flight
    @(posedge clk);
    #4;
    arst_n = 1'b0;
    #3;
    arst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    chk("R7 low mid release", ALL_LOW);
    arst_n = 1'b0;
    #1;
    chk("R7 reassert mid release", ALL_LOW);
    #5;
    arst_n = 1'b1;
    expect_release("R7 restart");

    // R7: reassert just before the final falling edge
    @(posedge clk);
    #1;
    arst_n = 1'b0;
    #2;
    arst_n = 1'b1;
    for (int n = 1; n <= LAT; n++) @(posedge clk);
    #2;
    arst_n = 1'b0;
    #1;
    chk("R7 reassert before final edge", ALL_LOW);
    @(negedge clk);
    #1;
    chk("R7 R2 no release while held", ALL_LOW);
    @(posedge clk);
    #3;
    arst_n = 1'b1;
    expect_release("R7 late restart");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule